// File: doc/BRIEF.md
# Four-Lane Single-Precision to BFloat16 Vector Converter

This block narrows a 128-bit vector of four IEEE binary32 values into a packed 64-bit vector of four BFloat16 values. Each lane is rounded to nearest with ties to even. The conversion always runs under one fixed standard setting, whatever the surrounding floating-point control state holds. Under that setting, NaNs become the default quiet NaN and subnormal inputs are flushed to a signed zero. Every accepted conversion ORs the exception flags raised by all four lanes into a sticky register. That register keeps its bits until a clear strobe arrives.

A request is one cycle of `in_valid` together with the operand and the low bit of the source register index. If that index bit is 1, the operation is illegal. The block then refuses it: it raises `out_undef` for one cycle, and it leaves the result register and the sticky flags untouched. A small output state machine records what happened at the last edge. It has three states: `ST_IDLE` (no request), `ST_DONE` (a conversion was accepted) and `ST_REFUSED` (an illegal request was seen). From any state, a legal strobe moves it to `ST_DONE`, an illegal strobe moves it to `ST_REFUSED`, and no strobe moves it to `ST_IDLE`.

Top module: `bfc_vec_cvt`

## Requirements
- R1: Source lane e (bits 32e+31..32e) is converted into result lane e (bits 16e+15..16e). The result appears on `out_vec` with `out_valid` high for exactly one cycle, in the cycle after the edge that samples a legal strobe. `out_vec` keeps its value until the next legal strobe.
- R2: Finite normal inputs round to nearest on the 16 discarded bits, with ties going to the even result. Examples: 0x3F808000→0x3F80, 0x3F818000→0x3F82, 0x3F808001→0x3F81, 0x3F807FFF→0x3F80.
- R3: A round-up that carries into the exponent is propagated (0x3FFFFFFF→0x4000). If the rounded magnitude exceeds the largest finite BFloat16, the result is a signed infinity (0x7F80 or 0xFF80) and both the overflow and inexact flags are set.
- R4: Every NaN input yields 0x7FC0 whatever its sign and payload. A signaling NaN (fraction MSB 0) sets the invalid flag. A quiet NaN sets no flag.
- R5: A subnormal input becomes a zero of the same sign and sets only the input-denormal flag.
- R6: Infinities and zeros pass through with their sign and raise no flag.
- R7: The inexact flag is set only when the discarded bits of a finite normal input are nonzero. Exactly representable inputs raise no flag.
- R8: `sticky_flags` bit 0 is invalid, bit 1 overflow, bit 2 inexact and bit 3 input-denormal. The flags of all four lanes are ORed together and then ORed into the register, and bits stay set across later conversions.
- R9: A `flag_clr` strobe clears the sticky flags at the next edge. When a legal conversion arrives in the same cycle, only that conversion's flags remain.
- R10: A strobe with `src_idx_lsb`=1 raises `out_undef` for one cycle and does not raise `out_valid`. It changes neither `out_vec` nor `sticky_flags`.
- R11: After reset, `out_vec`, `out_valid`, `out_undef` and `sticky_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle request strobe |
| in_vec | input | 128 | Four binary32 source lanes |
| src_idx_lsb | input | 1 | Low bit of the source register index; 1 marks an illegal request |
| flag_clr | input | 1 | Clears the sticky exception flags |
| out_vec | output | 64 | Four packed BFloat16 results |
| out_valid | output | 1 | Result accepted and updated |
| out_undef | output | 1 | Illegal request refused |
| sticky_flags | output | 4 | Cumulative flags {denormal, inexact, overflow, invalid} |

## Verification
Every fault in this block shows up at the ports one cycle after the strobe that exposes it. A wrong output state shows as a missing, doubled or misplaced `out_valid` or `out_undef` pulse. A fault in a lane's rounding or special-case path shows as a wrong 16-bit field of `out_vec` in that cycle. A sticky register that merges, clears or holds wrongly shows in `sticky_flags` in the same cycle, and it stays wrong until the next clear. For that reason the flags are compared after every request, refused ones included.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
    localparam int unsigned SRC_W      = 32;
    localparam int unsigned DST_W      = 16;
    localparam int unsigned EXP_W      = 8;
    localparam int unsigned SRC_FRAC_W = SRC_W - EXP_W - 1;
    localparam int unsigned DST_FRAC_W = DST_W - EXP_W - 1;
    localparam int unsigned DROP_W     = SRC_W - DST_W;
    localparam logic [DST_W-1:0] QNAN_DEF = 16'h7FC0;

    typedef struct packed {
        logic idc;   // input denormal flushed
        logic ixc;   // inexact
        logic ofc;   // overflow
        logic ioc;   // invalid operation
    } fexc_t;

    localparam int unsigned FEXC_W = $bits(fexc_t);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DONE    = 2'd1,
        ST_REFUSED = 2'd2
    } ostate_t;
endpackage

// File: rtl/bfc_lane.sv
module bfc_lane
    import bfc_pkg::*;
(
    input  logic [SRC_W-1:0] src,
    output logic [DST_W-1:0] dst,
    output fexc_t            exc
);
    logic                  sgn;
    logic [EXP_W-1:0]      ex;
    logic [SRC_FRAC_W-1:0] fr;
    logic [DST_W-2:0]      kept;
    logic [DST_W-2:0]      mag;
    logic                  guard_b;
    logic                  sticky_b;
    logic                  rnd_up;

    assign sgn      = src[SRC_W-1];
    assign ex       = src[SRC_W-2 -: EXP_W];
    assign fr       = src[SRC_FRAC_W-1:0];
    assign kept     = src[SRC_W-2:DROP_W];
    assign guard_b  = src[DROP_W-1];
    assign sticky_b = |src[DROP_W-2:0];
    assign rnd_up   = guard_b & (sticky_b | src[DROP_W]);
    assign mag      = kept + {{(DST_W-2){1'b0}}, rnd_up};

    always_comb begin
        dst = '0;
        exc = '0;
        if (ex == '1) begin
            if (fr != '0) begin
                dst     = QNAN_DEF;
                exc.ioc = ~fr[SRC_FRAC_W-1];
            end else begin
                dst = {sgn, kept};
            end
        end else if (ex == '0) begin
            dst     = {sgn, {(DST_W-1){1'b0}}};
            exc.idc = (fr != '0);
        end else begin
            dst     = {sgn, mag};
            exc.ixc = guard_b | sticky_b;
            exc.ofc = (mag[DST_W-2:DST_FRAC_W] == '1);
        end
    end

    // R4: any NaN leaving the lane is the canonical quiet NaN
    always_comb begin
        if (dst[DST_W-2:DST_FRAC_W] == '1 && dst[DST_FRAC_W-1:0] != '0) begin
            p_canon_nan_r4: assert (dst == QNAN_DEF)
                else $error("p_canon_nan_r4: non-default NaN %h", dst);
        end
    end

    // R3: overflow never comes without inexact
    always_comb begin
        p_ovf_inexact_r3: assert (!exc.ofc || exc.ixc)
            else $error("p_ovf_inexact_r3: overflow without inexact");
    end
endmodule

// File: rtl/bfc_flag_acc.sv
module bfc_flag_acc
    import bfc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  merge_en,
    input  fexc_t merge_in,
    output fexc_t sticky
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= '0;
        end else if (clr) begin
            sticky <= merge_en ? merge_in : '0;
        end else if (merge_en) begin
            sticky <= sticky | merge_in;
        end
    end

    p_sticky_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((sticky & $past(sticky)) == $past(sticky)))
        else $error("p_sticky_keep_r8: a sticky bit dropped");

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !merge_en) |=> (sticky == '0))
        else $error("p_clear_r9: flags not cleared");
endmodule

// File: rtl/bfc_vec_cvt.sv
module bfc_vec_cvt
    import bfc_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned IN_W  = LANES * SRC_W,
    localparam int unsigned OUT_W = LANES * DST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_vec,
    input  logic             src_idx_lsb,
    input  logic             flag_clr,
    output logic [OUT_W-1:0] out_vec,
    output logic             out_valid,
    output logic             out_undef,
    output logic [FEXC_W-1:0] sticky_flags
);
    ostate_t          state_q;
    ostate_t          state_d;
    logic [OUT_W-1:0] conv_vec;
    fexc_t            lane_exc [LANES];
    fexc_t            all_exc;
    fexc_t            sticky_q;
    logic             accept;

    assign accept = in_valid & ~src_idx_lsb;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bfc_lane u_lane (
            .src (in_vec[g*SRC_W +: SRC_W]),
            .dst (conv_vec[g*DST_W +: DST_W]),
            .exc (lane_exc[g])
        );
    end

    always_comb begin
        all_exc = '0;
        for (int i = 0; i < LANES; i++) begin
            all_exc = all_exc | lane_exc[i];
        end
    end

    bfc_flag_acc u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flag_clr),
        .merge_en (accept),
        .merge_in (all_exc),
        .sticky   (sticky_q)
    );

    assign sticky_flags = sticky_q;

    always_comb begin
        if (!in_valid)        state_d = ST_IDLE;
        else if (src_idx_lsb) state_d = ST_REFUSED;
        else                  state_d = ST_DONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      out_vec <= '0;
        else if (accept) out_vec <= conv_vec;
    end

    always_comb begin
        out_valid = 1'b0;
        out_undef = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_DONE:    out_valid = 1'b1;
            ST_REFUSED: out_undef = 1'b1;
            default:    ;
        endcase
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !src_idx_lsb) |=> (out_valid && !out_undef))
        else $error("p_accept_r1: no result pulse");

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !src_idx_lsb) |=> ($stable(out_vec) && !out_valid))
        else $error("p_hold_r1: result moved without request");

    p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_idx_lsb && !flag_clr) |=> (out_undef && !out_valid && $stable(sticky_flags)))
        else $error("p_refuse_r10: refused request had an effect");
endmodule

// File: tb/bfc_vec_cvt_bench.sv
module bfc_vec_cvt_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_vec = '0;
    logic         src_idx_lsb = 1'b0;
    logic         flag_clr = 1'b0;
    logic [63:0]  out_vec;
    logic         out_valid;
    logic         out_undef;
    logic [3:0]   sticky_flags;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { logic [63:0] vec; bit undef; string req; } item_t;
    item_t sb_q[$];
    logic [63:0] last_vec = '0;
    logic [3:0]  exp_sticky = '0;

    always #5 clk = ~clk;

    bfc_vec_cvt u_bfc_vec_cvt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .src_idx_lsb(src_idx_lsb), .flag_clr(flag_clr), .out_vec(out_vec),
        .out_valid(out_valid), .out_undef(out_undef), .sticky_flags(sticky_flags)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [127:0] v, input logic [63:0] ev, input bit bad,
                         input logic [3:0] fx, input bit clr, input string req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_vec = v; src_idx_lsb = bad; flag_clr = clr;
        it.undef = bad; it.req = req;
        if (bad) it.vec = last_vec;
        else begin it.vec = ev; last_vec = ev; end
        sb_q.push_back(it);
        if (clr)       exp_sticky = bad ? 4'b0 : fx;
        else if (!bad) exp_sticky = exp_sticky | fx;
        @(negedge clk);
        in_valid = 1'b0; src_idx_lsb = 1'b0; flag_clr = 1'b0;
        chk(sticky_flags == exp_sticky, {req, " flags"}, 64'(sticky_flags), 64'(exp_sticky));
    endtask

    task automatic clear_only();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        exp_sticky = '0;
        chk(sticky_flags == 4'b0, "R9 clear", 64'(sticky_flags), 64'd0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (out_valid || out_undef)) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R1 unexpected output", out_vec, 64'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(out_undef == it.undef && out_valid == !it.undef,
                    {it.req, " strobe"}, {62'd0, out_valid, out_undef}, {62'd0, !it.undef, it.undef});
                chk(out_vec == it.vec, {it.req, " vec"}, out_vec, it.vec);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(out_vec == 64'd0, "R11 vec", out_vec, 64'd0);
        chk(out_valid == 1'b0, "R11 valid", 64'(out_valid), 64'd0);
        chk(out_undef == 1'b0, "R11 undef", 64'(out_undef), 64'd0);
        chk(sticky_flags == 4'd0, "R11 flags", 64'(sticky_flags), 64'd0);

        // R1 R6 R7: exact values, lane order
        drive({32'hC0200000, 32'h3F800000, 32'h7F7F0000, 32'h00000000},
              {16'hC020, 16'h3F80, 16'h7F7F, 16'h0000}, 1'b0, 4'b0000, 1'b0, "R1 R7 exact");
        // R2 ties to even, inexact only (bit 2)
        drive({32'h3F807FFF, 32'h3F808001, 32'h3F818000, 32'h3F808000},
              {16'h3F80, 16'h3F81, 16'h3F82, 16'h3F80}, 1'b0, 4'b0100, 1'b0, "R2 round");
        clear_only();
        // R3 carry and overflow
        drive({32'h3FFFFFFF, 32'h7F7FFFFF, 32'hFF7F8000, 32'h3F800000},
              {16'h4000, 16'h7F80, 16'hFF80, 16'h3F80}, 1'b0, 4'b0110, 1'b0, "R3 overflow");
        clear_only();
        // R4 quiet NaNs raise nothing
        drive({32'h7FC00001, 32'hFFC00000, 32'h7FC12345, 32'h3F800000},
              {16'h7FC0, 16'h7FC0, 16'h7FC0, 16'h3F80}, 1'b0, 4'b0000, 1'b0, "R4 qnan");
        // R4 signaling NaN raises invalid
        drive({32'h7F800001, 32'hFFA00000, 32'h7FC00000, 32'h00000000},
              {16'h7FC0, 16'h7FC0, 16'h7FC0, 16'h0000}, 1'b0, 4'b0001, 1'b0, "R4 snan");
        // R5 R6 R8: denormals flushed, accumulates with invalid
        drive({32'h00000001, 32'h807FFFFF, 32'hFF800000, 32'h80000000},
              {16'h0000, 16'h8000, 16'hFF80, 16'h8000}, 1'b0, 4'b1000, 1'b0, "R5 R6 R8 flush");
        // R10 refused request
        drive({32'h3FFFFFFF, 32'h7F7FFFFF, 32'hFF7F8000, 32'h7F800001},
              64'd0, 1'b1, 4'b0000, 1'b0, "R10 refuse");
        // R9 clear with simultaneous conversion
        drive({32'h3F807FFF, 32'h3F808001, 32'h3F818000, 32'h3F808000},
              {16'h3F80, 16'h3F81, 16'h3F82, 16'h3F80}, 1'b0, 4'b0100, 1'b1, "R9 clear+conv");
        // R8 exact conversion keeps sticky bit
        drive({32'h3F800000, 32'hC0200000, 32'h00000000, 32'h7F800000},
              {16'h3F80, 16'hC020, 16'h0000, 16'h7F80}, 1'b0, 4'b0000, 1'b0, "R8 hold");
        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R1 missing results", 64'(sb_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule